// File: doc/BRIEF.md
# Three-Key Combination Lock Controller

This block is a clocked Moore state machine that watches a small keypad and releases a lock once a fixed three-key code has been entered. Each cycle the keypad offers a press strobe and two key lines, all already synchronous to the clock. A press is seen as a single-cycle strobe. The secret code is key B, then key A, then key B.

The machine has two outputs. The first is a one-cycle release pulse. The second is a binary count of keys entered so far, which feeds an external display. A wrong key is never flagged. Instead the machine moves onto a parallel track of "wrong" states that keep counting, so the display shows the same progress whether or not the code is correct. Both outputs depend only on the current state.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous active-high reset `rst` forces the idle state, in which `key_count` is 0 and `unlock` is low.
- R2: The keypad word {key_vld, key_a, key_b} is decoded as follows: 110 is key A, 101 is key B, and 100 or 111 is a wrong key. Any word with key_vld=0 means no key, whatever the two key lines hold.
- R3: `key_count` reads 0 in idle. It reads 1 after the first key and 2 after the second key, on the correct path and on the wrong path alike. It reads 3 only while `unlock` is high.
- R4: `unlock` rises for exactly one cycle, after the keys B, A, B have been entered in that order. On the following edge the machine returns to idle (count 0) whatever the input.
- R5: From idle, key B starts the correct path (count 1). Key A or a wrong key starts the wrong path (count 1).
- R6: After a correct first key, key A advances the correct path (count 2). Key B or a wrong key moves to the wrong path at count 2.
- R7: After a correct second key, key B releases the lock. Key A or a wrong key returns to idle (count 0).
- R8: On the wrong path, any key at count 1 moves to count 2, and any key at count 2 returns to idle. `unlock` never rises on this path.
- R9: When no key is pressed, every state except the release state holds, so `key_count` does not change.
- R10: The display sequence for a wrong first key followed by any second key is the same as the sequence for a correct first two keys (1 then 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| key_vld | input | 1 | Single-cycle key press strobe |
| key_a | input | 1 | Key line A |
| key_b | input | 1 | Key line B |
| unlock | output | 1 | One-cycle release pulse |
| key_count | output | CNT_W (2) | Keys entered so far, binary |

## Verification
Both outputs are decoded straight from the state register. A key word that is present before a rising edge therefore shows its effect on `key_count` and `unlock` right after that same edge, with one edge of latency and no more. The release pulse falls on the edge after it rises. The bench drives each word on the falling edge, waits for one rising edge, and samples just after it, where it compares against a bench-side model stepped once for the same edge. The sweep covers every ordered triple of the eight keypad words starting from reset, and then repeats it with a no-key cycle after each press, so that every transition and every hold is exercised.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    // State encoding is part of the behaviour: count/unlock decode from it.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_OK1   = 3'b001,
        ST_OK2   = 3'b010,
        ST_OPEN  = 3'b011,
        ST_MISS1 = 3'b100,
        ST_MISS2 = 3'b101
    } lock_state_e;

    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_A    = 2'd1,
        KEY_B    = 2'd2,
        KEY_BAD  = 2'd3
    } key_cls_e;

    typedef struct packed {
        lock_state_e state;
    } lock_regs_t;

    localparam lock_regs_t LOCK_REGS_RST = '{state: ST_IDLE};

endpackage

// File: rtl/combo_key_decode.sv
module combo_key_decode
    import combo_lock_pkg::*;
(
    input  logic     key_vld,
    input  logic     key_a,
    input  logic     key_b,
    output key_cls_e key_cls
);
    always_comb begin
        if (!key_vld) begin
            key_cls = KEY_NONE;
        end else begin
            unique case ({key_a, key_b})
                2'b10:   key_cls = KEY_A;
                2'b01:   key_cls = KEY_B;
                default: key_cls = KEY_BAD;
            endcase
        end
    end
endmodule

// File: rtl/combo_next_state.sv
module combo_next_state
    import combo_lock_pkg::*;
(
    input  lock_state_e cur,
    input  key_cls_e    key_cls,
    output lock_state_e nxt
);
    logic pressed;
    assign pressed = (key_cls != KEY_NONE);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE: begin
                if (key_cls == KEY_B)  nxt = ST_OK1;
                else if (pressed)      nxt = ST_MISS1;
            end
            ST_OK1: begin
                if (key_cls == KEY_A)  nxt = ST_OK2;
                else if (pressed)      nxt = ST_MISS2;
            end
            ST_OK2: begin
                if (key_cls == KEY_B)  nxt = ST_OPEN;
                else if (pressed)      nxt = ST_IDLE;
            end
            ST_OPEN: begin
                nxt = ST_IDLE;
            end
            ST_MISS1: begin
                if (pressed)           nxt = ST_MISS2;
            end
            ST_MISS2: begin
                if (pressed)           nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/combo_out_decode.sv
module combo_out_decode
    import combo_lock_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  lock_state_e      cur,
    output logic             unlock,
    output logic [CNT_W-1:0] key_count
);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_THREE = CNT_W'(3);

    always_comb begin
        unlock    = 1'b0;
        key_count = '0;
        unique case (cur)
            ST_IDLE:  key_count = '0;
            ST_OK1,
            ST_MISS1: key_count = CNT_ONE;
            ST_OK2,
            ST_MISS2: key_count = CNT_TWO;
            ST_OPEN: begin
                key_count = CNT_THREE;
                unlock    = 1'b1;
            end
            default:  key_count = '0;
        endcase
    end
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
    import combo_lock_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_vld,
    input  logic             key_a,
    input  logic             key_b,
    output logic             unlock,
    output logic [CNT_W-1:0] key_count
);
    lock_regs_t  r_d, r_q;
    key_cls_e    key_cls;
    lock_state_e state_nxt;

    combo_key_decode u_dec (
        .key_vld (key_vld),
        .key_a   (key_a),
        .key_b   (key_b),
        .key_cls (key_cls)
    );

    combo_next_state u_nxt (
        .cur     (r_q.state),
        .key_cls (key_cls),
        .nxt     (state_nxt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= LOCK_REGS_RST;
        else     r_q <= r_d;
    end

    combo_out_decode #(.CNT_W(CNT_W)) u_out (
        .cur       (r_q.state),
        .unlock    (unlock),
        .key_count (key_count)
    );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             key_vld,
    input logic             key_a,
    input logic             key_b,
    input logic             unlock,
    input logic [CNT_W-1:0] key_count
);
    // R4
    unlock_single_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |=> !unlock);

    // R4
    unlock_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |=> (key_count == '0));

    // R3
    full_count_only_open_chk: assert property (@(posedge clk) disable iff (rst)
        (key_count == CNT_W'(3)) == unlock);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!key_vld && !unlock) |=> $stable(key_count));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        key_vld |=> (key_count == '0) || (key_count == $past(key_count) + CNT_W'(1)));

    // R7
    open_after_b_chk: assert property (@(posedge clk) disable iff (rst)
        (key_vld && key_b && !key_a && key_count == CNT_W'(2)) |=>
            (unlock || key_count == '0));
endmodule

bind combo_lock_fsm combo_lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_vld   (key_vld),
    .key_a     (key_a),
    .key_b     (key_b),
    .unlock    (unlock),
    .key_count (key_count)
);

// File: tb/sim_combo_lock_fsm.sv
`timescale 1ns/1ps
module sim_combo_lock_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_vld = 1'b0, key_a = 1'b0, key_b = 1'b0;
    logic       unlock;
    logic [1:0] key_count;

    int n_chk = 0;
    int n_bad = 0;
    int m_st  = 0;   // model: 0 idle, 1 ok1, 2 ok2, 3 open, 4 miss1, 5 miss2

    always #4 clk = ~clk;   // 125 MHz

    combo_lock_fsm u0 (
        .clk(clk), .rst(rst), .key_vld(key_vld), .key_a(key_a), .key_b(key_b),
        .unlock(unlock), .key_count(key_count)
    );

    // R2: 0 none, 1 A, 2 B, 3 wrong
    function automatic int classify(logic [2:0] w);
        if (!w[2]) return 0;
        if (w[1:0] == 2'b10) return 1;
        if (w[1:0] == 2'b01) return 2;
        return 3;
    endfunction

    function automatic int model_next(int s, int k);
        if (s == 3) return 0;
        if (k == 0) return s;
        case (s)
            0: return (k == 2) ? 1 : 4;
            1: return (k == 1) ? 2 : 5;
            2: return (k == 2) ? 3 : 0;
            4: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int model_cnt(int s);
        case (s)
            1, 4: return 1;
            2, 5: return 2;
            3:    return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int exp_cnt, logic exp_unl);
        n_chk++;
        if (key_count !== exp_cnt[1:0] || unlock !== exp_unl) begin
            n_bad++;
            $display("FAIL %s: count=%0d unlock=%b expected count=%0d unlock=%b",
                     tag, key_count, unlock, exp_cnt, exp_unl);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; {key_vld, key_a, key_b} = 3'b000;
        @(posedge clk); #1;
        m_st = 0;
        check("R1", 0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(logic [2:0] w);
        int    pre;
        string tag;
        @(negedge clk);
        {key_vld, key_a, key_b} = w;
        @(posedge clk); #1;
        pre  = m_st;
        m_st = model_next(pre, classify(w));
        if (pre == 3)                            tag = "R4";
        else if (!w[2] && w[1:0] != 2'b00)       tag = "R2";
        else if (!w[2])                          tag = "R9";
        else if (pre == 0)                       tag = "R5";
        else if (pre == 1)                       tag = "R6";
        else if (pre == 2)                       tag = "R7";
        else                                     tag = "R8";
        check(tag, model_cnt(m_st), m_st == 3);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();

        // R4: the code B, A, B releases, then idle whatever the input
        step(3'b101); step(3'b110); step(3'b101);
        step(3'b101);

        // R10: wrong first key shows the same 1,2 display as a right start
        do_reset();
        step(3'b110); check("R10", 1, 1'b0);
        step(3'b111); check("R10", 2, 1'b0);

        // Exhaustive triples from reset, with and without no-key gaps
        for (int gap = 0; gap < 2; gap++) begin
            for (int i = 0; i < 512; i++) begin
                do_reset();
                for (int j = 0; j < 3; j++) begin
                    step(3'((i >> (3 * j)) & 7));
                    if (gap == 1) step(3'b000);
                end
                step(3'b000);
                step(3'b000);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule